// File: doc/BRIEF.md
# ADC Sample-Sequencing DMA Engine

This engine steps through a list of analog conversions with no processor involvement. Software first writes a 24-bit start address. The list is then placed in a byte-wide external SRAM as two-byte entries, each holding a 4-bit channel code in the upper nibble of its first byte. Software then sets the enable bit. While enabled, the engine owns the SRAM port and signals this on `bus_grant`.

For each entry the engine reads the channel code and waits for a trigger. The trigger can be a single-shot command, a timer overflow or an external pulse. The engine then requests a conversion on that channel and writes the 12-bit result back over the same two bytes. The list ends with a repeat of the last channel followed by an entry with code 1111. The engine looks one entry ahead. When it sees the 1111 code in the next entry, it stops without converting or writing the repeated entry, and it raises `done_irq`.

A trigger that arrives while a fetch, conversion or write is still in flight is dropped, and `overrun` records the loss. Clearing the enable bit, or a reset, aborts the run at once and releases the memory port.

Top module: `adc_seq_dma`

## Requirements
- R1: After reset, `bus_grant`, `adc_req`, `mem_rd`, `mem_wr`, `done_irq` and `overrun` are all 0.
- R2: Register writes with `reg_addr` 0, 1 and 2 load bits 7:0, 15:8 and 23:16 of the start pointer. These writes are made in that order. The first read after enabling is at exactly that address.
- R3: Pointer writes are ignored while `adc_mode` is nonzero (converter powered) or while the engine is enabled.
- R4: A write to `reg_addr` 3 sets the enable bit from bit 6 of the data, so 0x40 enables the engine. `bus_grant` equals the enable bit from the next cycle on. A 0-to-1 enable starts a run at the pointer.
- R5: In a waiting entry, a one-cycle pulse on any of `trig_single`, `trig_timer` or `trig_ext` raises `adc_req`. `adc_ch` carries bits 7:4 of the entry's first byte. The request holds until `adc_done`.
- R6: On `adc_done`, the engine writes `{channel, result[11:8]}` to the entry's first byte in the next cycle. It writes `result[7:0]` to the following byte in the cycle after that. The pointer then advances by 2.
- R7: When the entry after the current one holds code 1111 in bits 7:4, the run stops. Neither the current entry nor the 1111 entry is converted or written, and `done_irq` is set and held.
- R8: A trigger pulse while a fetch, conversion or result write is pending starts no extra conversion and sets `overrun`.
- R9: Writing the enable bit to 0 returns the engine to idle in the next cycle. `bus_grant`, `adc_req`, `mem_rd` and `mem_wr` then drop.
- R10: `mem_rd` and `mem_wr` are never high together, and neither is high while `bus_grant` is low.
- R11: Starting a new run clears `done_irq` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 pointer low, 1 pointer middle, 2 pointer page, 3 control |
| reg_wdata | input | 8 | Register write data; control bit 6 is enable |
| adc_mode | input | 2 | Converter power mode; 0 means powered down |
| trig_single | input | 1 | Single-conversion command pulse |
| trig_timer | input | 1 | Timer overflow pulse |
| trig_ext | input | 1 | External trigger pulse |
| adc_req | output | 1 | Conversion request, held until done |
| adc_ch | output | 4 | Channel to convert |
| adc_done | input | 1 | Conversion complete, result valid |
| adc_result | input | 12 | Conversion result |
| mem_addr | output | 24 | SRAM byte address |
| mem_rd | output | 1 | SRAM read; data returns one cycle later |
| mem_wr | output | 1 | SRAM write |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data |
| bus_grant | output | 1 | Engine owns the memory port; core accesses are blocked |
| done_irq | output | 1 | Run-complete flag |
| overrun | output | 1 | A trigger was lost while busy |

## Verification
The main run uses six entries. Their channel codes are all distinct, and their results cover all ones, all zeros and mixed bit patterns. This separates a swapped nibble or byte from a correct write. The three trigger sources are used in rotation, so a source that is not wired shows up as a missing request. Shorter lists test the stop logic. One list is a single converted entry followed by the stop pair. Another starts directly on a 1111 code. Together they show whether the lookahead stops too early or writes into the stop pair. The remaining cases each probe one control path: a pointer load attempted while the converter is powered, a trigger during a conversion, and an abort in mid-conversion.

// File: rtl/adc_seq_dma.sv
module adc_seq_dma #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic [1:0]    adc_mode,
  input  logic          trig_single,
  input  logic          trig_timer,
  input  logic          trig_ext,
  output logic          adc_req,
  output logic [3:0]    adc_ch,
  input  logic          adc_done,
  input  logic [11:0]   adc_result,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          bus_grant,
  output logic          done_irq,
  output logic          overrun
);
  localparam logic [3:0] STOP = 4'hF;
  localparam int NPB = (AW + 7) / 8;

  typedef enum logic [3:0] {IDLE, RD0, RD1, CHK, WAITT, CONV, WRH, WRL, FIN} st_t;

  st_t          st;
  logic         en, irq, ovr;
  logic [AW-1:0] ptr;
  logic [3:0]   ch;
  logic [11:0]  res;

  logic trig, busy, ctl_wr, start, stop, ptr_ok;
  assign trig   = trig_single | trig_timer | trig_ext;
  assign busy   = st inside {RD0, RD1, CHK, CONV, WRH, WRL};
  assign ctl_wr = reg_we && reg_addr == 2'd3;
  assign start  = ctl_wr && reg_wdata[6] && !en;
  assign stop   = ctl_wr && !reg_wdata[6];
  assign ptr_ok = reg_we && reg_addr != 2'd3 && adc_mode == 2'b00 && !en;

  logic unused_low;
  assign unused_low = ^{mem_rdata[3:0], reg_wdata[7], reg_wdata[5:0] & 6'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IDLE;
      en  <= 1'b0;
      irq <= 1'b0;
      ovr <= 1'b0;
      ptr <= '0;
      ch  <= '0;
      res <= '0;
    end else begin
      if (ctl_wr) en <= reg_wdata[6];
      if (stop) begin
        st <= IDLE;
      end else if (start) begin
        st  <= RD0;
        irq <= 1'b0;
        ovr <= 1'b0;
      end else begin
        if (trig && busy) ovr <= 1'b1;
        case (st)
          RD0:   st <= RD1;
          RD1:   begin ch <= mem_rdata[7:4]; st <= CHK; end
          CHK:   if (ch == STOP || mem_rdata[7:4] == STOP) begin
                   st  <= FIN;
                   irq <= 1'b1;
                 end else st <= WAITT;
          WAITT: if (trig) st <= CONV;
          CONV:  if (adc_done) begin res <= adc_result; st <= WRH; end
          WRH:   st <= WRL;
          WRL:   begin ptr <= ptr + AW'(2); st <= RD0; end
          default: ;
        endcase
      end
      for (int b = 0; b < NPB; b++)
        if (ptr_ok && int'(reg_addr) == b)
          for (int k = 0; k < 8; k++)
            if (b * 8 + k < AW) ptr[b*8+k] <= reg_wdata[k];
    end
  end

  assign adc_req   = st == CONV;
  assign adc_ch    = ch;
  assign mem_rd    = st == RD0 || st == RD1;
  assign mem_wr    = st == WRH || st == WRL;
  assign mem_addr  = st == RD1 ? ptr + AW'(2) : st == WRL ? ptr + AW'(1) : ptr;
  assign mem_wdata = st == WRH ? {ch, res[11:8]} : res[7:0];
  assign bus_grant = en;
  assign done_irq  = irq;
  assign overrun   = ovr;
endmodule

module adc_seq_dma_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          adc_req,
  input logic          adc_done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          bus_grant,
  input logic          done_irq
);
  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R10
  quiet_ungranted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant |-> !mem_rd && !mem_wr && !adc_req);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && !adc_done && !reg_we |=> adc_req);
  // R6
  wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && adc_done && !reg_we |=> mem_wr);
  // R6
  wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) && !reg_we |=> mem_wr && mem_addr == $past(mem_addr) + AW'(1));
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !adc_req && !mem_wr);
  // R4
  grant_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 2'd3 |=> bus_grant == $past(reg_wdata[6]));
endmodule

bind adc_seq_dma adc_seq_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .adc_req(adc_req), .adc_done(adc_done),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .bus_grant(bus_grant), .done_irq(done_irq)
);

// File: tb/adc_seq_dma_bench.sv
`timescale 1ns/1ps
module adc_seq_dma_bench;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [1:0] adc_mode = 0;
  logic trig_single = 0, trig_timer = 0, trig_ext = 0;
  logic adc_req, adc_done = 0;
  logic [3:0] adc_ch;
  logic [11:0] adc_result = 0;
  logic [23:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [7:0] mem_wdata, mem_rdata;
  logic bus_grant, done_irq, overrun;
  logic [7:0] sram [64];
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  adc_seq_dma u_adc_seq_dma (.*);

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= sram[mem_addr[5:0]];
    if (mem_wr) sram[mem_addr[5:0]] <= mem_wdata;
  end

  // channel[15:12], result[11:0]
  localparam logic [15:0] RUN [6] = '{16'h2FFF, 16'h5000, 16'h3A5C,
                                      16'h8123, 16'hC800, 16'h17FF};

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic set_ptr(input logic [23:0] p);
    wr_reg(0, p[7:0]); wr_reg(1, p[15:8]); wr_reg(2, p[23:16]);
  endtask

  task automatic pulse(input int sel);
    if (sel == 0) trig_single = 1; else if (sel == 1) trig_timer = 1; else trig_ext = 1;
    @(negedge clk);
    trig_single = 0; trig_timer = 0; trig_ext = 0;
  endtask

  task automatic conv(input logic [3:0] ech, input logic [11:0] r, input logic [23:0] ea, input bit extra);
    int n = 0;
    while (!adc_req && n < 100) begin @(negedge clk); n++; end
    chk(adc_req, "R5 request", {31'b0, adc_req}, 1);
    chk(adc_ch == ech, "R5 channel", {28'b0, adc_ch}, {28'b0, ech});
    if (extra) pulse(1); else @(negedge clk);
    @(negedge clk);
    chk(adc_req, "R5 hold", {31'b0, adc_req}, 1);
    adc_result = r; adc_done = 1;
    @(negedge clk);
    adc_done = 0;
    chk(mem_wr && mem_addr == ea && mem_wdata == {ech, r[11:8]}, "R6 first byte",
        {mem_wr, mem_addr, mem_wdata[6:0]}, {1'b1, ea, ech[2:0], r[11:8]});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) sram[i] = 8'hA5;
    for (int i = 0; i < 6; i++) sram[2*i] = {RUN[i][15:12], 4'h0};
    sram[12] = 8'h10; sram[14] = 8'hF0;
    sram[32] = 8'h70; sram[34] = 8'h70; sram[36] = 8'hF0;
    sram[48] = 8'hF0;
    sram[56] = 8'h40; sram[58] = 8'h40; sram[60] = 8'hF0;
    repeat (3) @(negedge clk);
    // R1
    chk(!bus_grant && !adc_req && !mem_rd && !mem_wr && !done_irq && !overrun, "R1 reset",
        {26'b0, bus_grant, adc_req, mem_rd, mem_wr, done_irq, overrun}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 / R4 main run
    set_ptr(24'h123400);
    wr_reg(3, 8'h40);
    chk(mem_rd && mem_addr == 24'h123400, "R2 first read", {7'b0, mem_rd, mem_addr}, {8'h1, 24'h123400});
    chk(bus_grant, "R4 grant", {31'b0, bus_grant}, 1);
    for (int i = 0; i < 6; i++) begin
      repeat (6) @(negedge clk);
      pulse(i % 3);
      conv(RUN[i][15:12], RUN[i][11:0], 24'h123400 + 24'(2*i), 0);
    end
    repeat (10) @(negedge clk);
    chk(done_irq && !overrun, "R7 done flag", {30'b0, done_irq, overrun}, 2);
    for (int i = 0; i < 6; i++) begin
      chk(sram[2*i] == {RUN[i][15:12], RUN[i][11:8]}, "R6 stored high", {24'b0, sram[2*i]}, {24'b0, RUN[i][15:12], RUN[i][11:8]});
      chk(sram[2*i+1] == RUN[i][7:0], "R6 stored low", {24'b0, sram[2*i+1]}, {24'b0, RUN[i][7:0]});
    end
    chk({sram[12], sram[13], sram[14], sram[15]} == 32'h10A5F0A5, "R7 stop pair untouched",
        {sram[12], sram[13], sram[14], sram[15]}, 32'h10A5F0A5);

    // R9 stop, R3 pointer ignored while powered
    wr_reg(3, 8'h00);
    chk(!bus_grant && !mem_rd && !adc_req, "R9 idle", {29'b0, bus_grant, mem_rd, adc_req}, 0);
    adc_mode = 2'b01;
    set_ptr(24'h000020);
    adc_mode = 2'b00;
    wr_reg(3, 8'h40);
    chk(mem_addr == 24'h12340C, "R3 ptr kept", {8'b0, mem_addr}, {8'b0, 24'h12340C});
    chk(!done_irq, "R11 irq cleared", {31'b0, done_irq}, 0);
    repeat (6) @(negedge clk);
    chk(done_irq && !adc_req, "R7 dup stop", {30'b0, done_irq, adc_req}, 2);
    chk(sram[12] == 8'h10, "R7 dup unwritten", {24'b0, sram[12]}, 32'h10);
    // R3 pointer write while enabled is ignored
    wr_reg(0, 8'h30);
    wr_reg(3, 8'h00);

    // R8 overrun
    set_ptr(24'h000020);
    wr_reg(3, 8'h40);
    chk(mem_addr == 24'h000020, "R2 reload", {8'b0, mem_addr}, 32'h20);
    repeat (6) @(negedge clk);
    pulse(2);
    conv(4'h7, 12'h9B4, 24'h000020, 1);
    chk(overrun, "R8 overrun", {31'b0, overrun}, 1);
    repeat (10) @(negedge clk);
    chk(done_irq && !adc_req, "R8 no extra conversion", {30'b0, done_irq, adc_req}, 2);
    chk(sram[32] == 8'h79 && sram[33] == 8'hB4, "R6 short list", {16'b0, sram[32], sram[33]}, 32'h79B4);
    chk(sram[34] == 8'h70 && sram[35] == 8'hA5, "R7 short list stop", {16'b0, sram[34], sram[35]}, 32'h70A5);
    wr_reg(3, 8'h00);

    // R11 flags cleared, immediate stop code
    set_ptr(24'h000030);
    wr_reg(3, 8'h40);
    chk(!overrun && !done_irq, "R11 flags cleared", {30'b0, overrun, done_irq}, 0);
    repeat (6) @(negedge clk);
    chk(done_irq && sram[48] == 8'hF0, "R7 immediate stop", {23'b0, done_irq, sram[48]}, {23'b0, 1'b1, 8'hF0});
    wr_reg(3, 8'h00);

    // R9 abort mid-conversion
    set_ptr(24'h000038);
    wr_reg(3, 8'h40);
    repeat (6) @(negedge clk);
    pulse(0);
    @(negedge clk);
    chk(adc_req && adc_ch == 4'h4, "R5 single trigger", {27'b0, adc_req, adc_ch}, 32'h14);
    wr_reg(3, 8'h00);
    chk(!bus_grant && !adc_req && !mem_wr && !mem_rd, "R9 abort",
        {28'b0, bus_grant, adc_req, mem_wr, mem_rd}, 0);
    repeat (4) @(negedge clk);
    chk(sram[56] == 8'h40 && !adc_req, "R10 no write after abort", {23'b0, adc_req, sram[56]}, 32'h40);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule